// File: doc/BRIEF.md
# Symmetric Flow Hash Dispatcher

This block spreads parsed packet tuples over a set of work queues so that many consumer threads can share the traffic without locking session state. Each accepted tuple (two IPv4 addresses, two L4 ports, protocol) is reduced to a queue index by a hash over the fields that software enables. Before hashing, each address pair and each port pair is put in order, so the client-to-server and server-to-client flows of one session select the same queue. All packets of a flow therefore reach one queue, and their order within the flow is kept.

Next to the hash, the block keeps a packet count and an ownership lock for every queue. A consumer that dequeues a packet becomes the queue's owner. No other consumer can take a packet from that queue until the owner sends an explicit release. A consumer can hold several queues at once. Packets are not stored here: the block only tracks how many packets each queue holds, and the owning thread fetches the packet bodies elsewhere.

Top module: `sfd_dispatch`

## Requirements
- R1: The queue index is the low log2(NQ) bits of g. With lo/hi being the smaller/larger of the two addresses (A) and of the two ports (P), m = A_lo ^ rotate_left(A_hi, 7) ^ {P_lo, P_hi} ^ {24'b0, proto}; f = m[31:16] ^ m[15:0]; g = f[15:8] ^ f[7:0].
- R2: cfg_field_en bit 0 enables the addresses, bit 1 the ports and bit 2 the protocol. A disabled field enters the hash as zero, so cfg_field_en = 0 sends every tuple to queue 0.
- R3: Swapping the source and destination addresses together with the source and destination ports gives the same queue index.
- R4: out_valid is high exactly one cycle after a handshake where in_valid and in_ready are both high. out_qidx in that cycle is the queue index of the accepted tuple.
- R5: in_ready is low while the queue that the presented tuple maps to already holds DEPTH packets. Such a tuple is not counted.
- R6: A dequeue request is answered in the next cycle on exactly one of grant, empty or busy. A grant happens when the queue holds a packet and is free or held by the requester. A grant removes one packet and makes the requester the owner.
- R7: A request to a queue held by another consumer gets busy. Neither the count nor the owner changes.
- R8: A request to a queue with no packets gets empty and takes no ownership. Another consumer can still be granted that queue once it holds a packet.
- R9: A release by the owner frees the queue. A release by any other consumer is ignored.
- R10: Within one cycle, all releases take effect before any request. Requests are resolved in ascending consumer index, so the lowest requester wins a free queue and later requesters see it held.
- R11: After reset all queues are empty and unowned. out_valid and every grant, empty and busy output are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_field_en | input | 3 | Hash field enables: bit0 addresses, bit1 ports, bit2 protocol |
| in_valid | input | 1 | Tuple valid |
| in_ready | output | 1 | Tuple can be accepted (target queue not full) |
| in_src_ip | input | 32 | Source IPv4 address |
| in_dst_ip | input | 32 | Destination IPv4 address |
| in_src_port | input | 16 | Source L4 port |
| in_dst_port | input | 16 | Destination L4 port |
| in_proto | input | 8 | IP protocol number |
| out_valid | output | 1 | Queue index valid, one cycle after accept |
| out_qidx | output | QW | Queue index of the accepted tuple |
| deq_req | input | NC | Per-consumer dequeue request |
| deq_qsel | input | NC*QW | Per-consumer requested queue, consumer c in bits [c*QW +: QW] |
| deq_grant | output | NC | Packet granted, requester now owns the queue |
| deq_empty | output | NC | Requested queue held no packet |
| deq_busy | output | NC | Requested queue owned by another consumer |
| rel_req | input | NC | Per-consumer release request |
| rel_qsel | input | NC*QW | Per-consumer queue to release |

## Verification
The bench builds the block with its defaults: 16 queues, 4 consumers and a per-queue depth of 8. The small depth means a disabled-field configuration can fill queue 0 in a few cycles, which exercises the full back-pressure path. Four consumers give enough requesters to test a same-cycle contention, a same-cycle release and re-request, and a refused release from a non-owner. A behavioural model of counts and owners predicts every output on every clock. The bench also compares forward and swapped tuples directly to check that the hash is symmetric.

// File: rtl/sfd_pkg.sv
package sfd_pkg;

    localparam int unsigned FE_ADDR  = 0;
    localparam int unsigned FE_PORT  = 1;
    localparam int unsigned FE_PROTO = 2;
    localparam int unsigned ROT      = 7;

    // Mix ordered, masked fields into 32 bits, then fold to 8 bits.
    function automatic logic [7:0] sfd_fold(
        input logic [31:0] a_lo,
        input logic [31:0] a_hi,
        input logic [15:0] p_lo,
        input logic [15:0] p_hi,
        input logic [7:0]  pr
    );
        logic [31:0] m;
        logic [15:0] f;
        m = a_lo ^ {a_hi[31-ROT:0], a_hi[31:32-ROT]} ^ {p_lo, p_hi} ^ {24'd0, pr};
        f = m[31:16] ^ m[15:0];
        return f[15:8] ^ f[7:0];
    endfunction

endpackage

// File: rtl/sfd_hash.sv
module sfd_hash
    import sfd_pkg::*;
#(
    parameter int unsigned QW = 4
) (
    input  logic [2:0]    field_en,
    input  logic [31:0]   src_ip,
    input  logic [31:0]   dst_ip,
    input  logic [15:0]   src_port,
    input  logic [15:0]   dst_port,
    input  logic [7:0]    proto,
    output logic [QW-1:0] qidx
);
    logic [31:0] a_s, a_d, a_lo, a_hi;
    logic [15:0] p_s, p_d, p_lo, p_hi;
    logic [7:0]  pr;
    logic [7:0]  g;

    always_comb begin
        a_s  = field_en[FE_ADDR] ? src_ip   : '0;
        a_d  = field_en[FE_ADDR] ? dst_ip   : '0;
        p_s  = field_en[FE_PORT] ? src_port : '0;
        p_d  = field_en[FE_PORT] ? dst_port : '0;
        pr   = field_en[FE_PROTO] ? proto   : '0;
        // Direction-independent ordering of each pair.
        a_lo = (a_s < a_d) ? a_s : a_d;
        a_hi = (a_s < a_d) ? a_d : a_s;
        p_lo = (p_s < p_d) ? p_s : p_d;
        p_hi = (p_s < p_d) ? p_d : p_s;
        g    = sfd_fold(a_lo, a_hi, p_lo, p_hi, pr);
        qidx = g[QW-1:0];
    end
endmodule

// File: rtl/sfd_queue_ctrl.sv
module sfd_queue_ctrl #(
    parameter int unsigned NC    = 4,
    parameter int unsigned QW    = 4,
    parameter int unsigned DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enq_valid,
    input  logic [QW-1:0]    enq_qidx,
    output logic             enq_full,
    input  logic [NC-1:0]    deq_req,
    input  logic [NC*QW-1:0] deq_qsel,
    input  logic [NC-1:0]    rel_req,
    input  logic [NC*QW-1:0] rel_qsel,
    output logic [NC-1:0]    grant,
    output logic [NC-1:0]    empty,
    output logic [NC-1:0]    busy
);
    localparam int unsigned NQ = 1 << QW;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam int unsigned IW = (NC > 1) ? $clog2(NC) : 1;

    typedef struct packed {
        logic [NQ-1:0][CW-1:0] cnt;
        logic [NQ-1:0]         held;
        logic [NQ-1:0][IW-1:0] owner;
        logic [NC-1:0]         grant;
        logic [NC-1:0]         empty;
        logic [NC-1:0]         busy;
    } state_t;

    state_t st_q, st_d;

    assign enq_full = (st_q.cnt[enq_qidx] == CW'(DEPTH));

    always_comb begin
        logic [QW-1:0] qs;
        st_d       = st_q;
        st_d.grant = '0;
        st_d.empty = '0;
        st_d.busy  = '0;
        // Releases first: only the current owner may free a queue.
        for (int c = 0; c < NC; c++) begin
            qs = rel_qsel[c*QW +: QW];
            if (rel_req[c] && st_q.held[qs] && st_q.owner[qs] == IW'(c)) begin
                st_d.held[qs] = 1'b0;
            end
        end
        // Requests in ascending consumer order.
        for (int c = 0; c < NC; c++) begin
            qs = deq_qsel[c*QW +: QW];
            if (deq_req[c]) begin
                if (st_d.held[qs] && st_d.owner[qs] != IW'(c)) begin
                    st_d.busy[c] = 1'b1;
                end else if (st_q.cnt[qs] == '0) begin
                    st_d.empty[c] = 1'b1;
                end else begin
                    st_d.grant[c]  = 1'b1;
                    st_d.held[qs]  = 1'b1;
                    st_d.owner[qs] = IW'(c);
                    st_d.cnt[qs]   = st_d.cnt[qs] - CW'(1);
                end
            end
        end
        if (enq_valid) begin
            st_d.cnt[enq_qidx] = st_d.cnt[enq_qidx] + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant = st_q.grant;
    assign empty = st_q.empty;
    assign busy  = st_q.busy;
endmodule

// File: rtl/sfd_dispatch.sv
module sfd_dispatch #(
    parameter int unsigned NC    = 4,
    parameter int unsigned QW    = 4,
    parameter int unsigned DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cfg_field_en,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [31:0]      in_src_ip,
    input  logic [31:0]      in_dst_ip,
    input  logic [15:0]      in_src_port,
    input  logic [15:0]      in_dst_port,
    input  logic [7:0]       in_proto,
    output logic             out_valid,
    output logic [QW-1:0]    out_qidx,
    input  logic [NC-1:0]    deq_req,
    input  logic [NC*QW-1:0] deq_qsel,
    output logic [NC-1:0]    deq_grant,
    output logic [NC-1:0]    deq_empty,
    output logic [NC-1:0]    deq_busy,
    input  logic [NC-1:0]    rel_req,
    input  logic [NC*QW-1:0] rel_qsel
);
    typedef struct packed {
        logic          vld;
        logic [QW-1:0] idx;
    } out_t;

    out_t          o_q, o_d;
    logic [QW-1:0] hq;
    logic          full;
    logic          accept;

    sfd_hash #(.QW(QW)) hash_i (
        .field_en (cfg_field_en),
        .src_ip   (in_src_ip),
        .dst_ip   (in_dst_ip),
        .src_port (in_src_port),
        .dst_port (in_dst_port),
        .proto    (in_proto),
        .qidx     (hq)
    );

    assign in_ready = ~full;
    assign accept   = in_valid & ~full;

    sfd_queue_ctrl #(.NC(NC), .QW(QW), .DEPTH(DEPTH)) qctl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .enq_valid (accept),
        .enq_qidx  (hq),
        .enq_full  (full),
        .deq_req   (deq_req),
        .deq_qsel  (deq_qsel),
        .rel_req   (rel_req),
        .rel_qsel  (rel_qsel),
        .grant     (deq_grant),
        .empty     (deq_empty),
        .busy      (deq_busy)
    );

    always_comb begin
        o_d     = o_q;
        o_d.vld = accept;
        if (accept) begin
            o_d.idx = hq;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign out_valid = o_q.vld;
    assign out_qidx  = o_q.idx;
endmodule

// File: rtl/sfd_dispatch_chk.sv
module sfd_dispatch_chk #(
    parameter int unsigned NC = 4,
    parameter int unsigned QW = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic [NC-1:0]    deq_req,
    input logic [NC*QW-1:0] deq_qsel,
    input logic [NC-1:0]    deq_grant,
    input logic [NC-1:0]    deq_empty,
    input logic [NC-1:0]    deq_busy
);
    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    p_out_after_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (out_valid == $past(in_valid && in_ready)));

    for (genvar c = 0; c < NC; c++) begin : g_cons
        p_one_answer_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0({deq_grant[c], deq_empty[c], deq_busy[c]}));

        p_answer_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && (deq_grant[c] || deq_empty[c] || deq_busy[c])) |-> $past(deq_req[c]));

        for (genvar k = c + 1; k < NC; k++) begin : g_pair
            p_single_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (armed && deq_grant[c] && deq_grant[k]) |->
                    ($past(deq_qsel[c*QW +: QW]) != $past(deq_qsel[k*QW +: QW])));
        end
    end
endmodule

bind sfd_dispatch sfd_dispatch_chk #(.NC(NC), .QW(QW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .deq_req   (deq_req),
    .deq_qsel  (deq_qsel),
    .deq_grant (deq_grant),
    .deq_empty (deq_empty),
    .deq_busy  (deq_busy)
);

// File: tb/sfd_dispatch_tb_top.sv
module sfd_dispatch_tb_top;
    localparam int NC = 4, QW = 4, NQ = 16, DEPTH = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic             rst_n;
    logic [2:0]       cfg_field_en;
    logic             in_valid, in_ready;
    logic [31:0]      in_src_ip, in_dst_ip;
    logic [15:0]      in_src_port, in_dst_port;
    logic [7:0]       in_proto;
    logic             out_valid;
    logic [QW-1:0]    out_qidx;
    logic [NC-1:0]    deq_req, deq_grant, deq_empty, deq_busy, rel_req;
    logic [NC*QW-1:0] deq_qsel, rel_qsel;

    sfd_dispatch #(.NC(NC), .QW(QW), .DEPTH(DEPTH)) dut_i (.*);

    int cnt_m[NQ];
    int own_m[NQ];
    int n_run = 0, n_fail = 0;
    bit done = 0;

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic int ref_hash(logic [2:0] en, logic [31:0] sa, logic [31:0] da,
                                    logic [15:0] sp, logic [15:0] dp, logic [7:0] pr);
        logic [31:0] lo, hi, m;
        logic [15:0] plo, phi, f;
        logic [7:0] g;
        if (!en[0]) begin sa = 0; da = 0; end
        if (!en[1]) begin sp = 0; dp = 0; end
        if (!en[2]) pr = 0;
        if (sa < da) begin lo = sa; hi = da; end else begin lo = da; hi = sa; end
        if (sp < dp) begin plo = sp; phi = dp; end else begin plo = dp; phi = sp; end
        m = lo ^ ((hi << 7) | (hi >> 25)) ^ ((32'(plo) << 16) | 32'(phi)) ^ 32'(pr);
        f = m[31:16] ^ m[15:0];
        g = f[15:8] ^ f[7:0];
        return int'(g) % NQ;
    endfunction

    // One clock: predict, advance, compare.
    task automatic step(string tag);
        int h;
        bit acc;
        logic [NC-1:0] eg, ee, eb;
        eg = 0; ee = 0; eb = 0;
        h = ref_hash(cfg_field_en, in_src_ip, in_dst_ip, in_src_port, in_dst_port, in_proto);
        if (in_valid) chk("R5 in_ready", in_ready, cnt_m[h] < DEPTH);
        acc = in_valid && (cnt_m[h] < DEPTH);
        for (int c = 0; c < NC; c++) begin
            int q = int'(rel_qsel[c*QW +: QW]);
            if (rel_req[c] && own_m[q] == c) own_m[q] = -1;
        end
        for (int c = 0; c < NC; c++) begin
            int q = int'(deq_qsel[c*QW +: QW]);
            if (deq_req[c]) begin
                if (own_m[q] != -1 && own_m[q] != c) eb[c] = 1;
                else if (cnt_m[q] == 0) ee[c] = 1;
                else begin eg[c] = 1; own_m[q] = c; cnt_m[q]--; end
            end
        end
        if (acc) cnt_m[h]++;
        @(posedge clk); #1;
        chk("R4 out_valid", out_valid, acc);
        if (acc) chk("R1 out_qidx", out_qidx, h);
        chk({tag, " grant"}, deq_grant, eg);
        chk({tag, " empty"}, deq_empty, ee);
        chk({tag, " busy"}, deq_busy, eb);
    endtask

    task automatic idle();
        in_valid = 0; deq_req = 0; rel_req = 0;
    endtask

    task automatic tup(logic [31:0] sa, logic [31:0] da, logic [15:0] sp, logic [15:0] dp,
                       logic [7:0] pr);
        in_valid = 1; in_src_ip = sa; in_dst_ip = da;
        in_src_port = sp; in_dst_port = dp; in_proto = pr;
    endtask

    task automatic req(int c, int q);
        deq_req[c] = 1; deq_qsel[c*QW +: QW] = QW'(q);
    endtask

    task automatic rel(int c, int q);
        rel_req[c] = 1; rel_qsel[c*QW +: QW] = QW'(q);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [QW-1:0] fwd;
        for (int q = 0; q < NQ; q++) begin cnt_m[q] = 0; own_m[q] = -1; end
        rst_n = 0; cfg_field_en = 3'b111; deq_qsel = 0; rel_qsel = 0;
        in_src_ip = 0; in_dst_ip = 0; in_src_port = 0; in_dst_port = 0; in_proto = 0;
        idle();
        repeat (3) @(posedge clk);
        #1;
        chk("R11 out_valid", out_valid, 0);
        chk("R11 responses", {deq_grant, deq_empty, deq_busy}, 0);
        rst_n = 1;
        @(posedge clk); #1;
        // R11: every queue starts empty
        req(0, 3); req(1, 9); step("R11");
        idle();

        // R1 / R3: forward and swapped tuples
        for (int i = 0; i < 6; i++) begin
            tup(32'h0A00_0001 + i * 32'h0101_0307, 32'hC0A8_1001 - i * 32'h0013_0101,
                16'(1024 + i * 771), 16'(80 + i * 13), 8'(6 + i * 11));
            step("R1");
            fwd = out_qidx;
            tup(in_dst_ip, in_src_ip, in_dst_port, in_src_port, in_proto);
            step("R1");
            chk("R3 symmetric", out_qidx, fwd);
        end
        idle();

        // R2: field-enable subsets
        for (int en = 0; en < 8; en++) begin
            cfg_field_en = 3'(en);
            tup(32'h1234_5678, 32'h9ABC_DEF0, 16'h1F90, 16'h0035, 8'd17);
            step("R2");
            if (en == 0) chk("R2 all-disabled to q0", out_qidx, 0);
        end
        idle();

        // R5: fill queue 0 with all fields disabled
        cfg_field_en = 3'b000;
        for (int i = 0; i < DEPTH + 3; i++) begin
            tup(32'(i), 32'(i * 7), 16'(i), 16'(i + 1), 8'(i));
            step("R5");
        end
        chk("R5 full queue stalls", in_ready, 0);
        idle();

        // R6 / R7 / R9 / R10: ownership on queue 0
        req(0, 0); step("R6"); idle();
        req(1, 0); step("R7"); idle();
        rel(1, 0); step("R9"); idle();
        req(1, 0); step("R9"); idle();
        chk("R9 non-owner release ignored", deq_busy[1], 1);
        req(0, 0); step("R6"); idle();
        rel(0, 0); req(1, 0); step("R10"); idle();
        chk("R10 release before request", deq_grant[1], 1);
        req(2, 0); req(3, 0); step("R7"); idle();
        rel(1, 0); step("R9"); idle();
        req(2, 0); req(3, 0); step("R10"); idle();
        chk("R10 lowest index wins", {deq_grant[2], deq_busy[3]}, 2'b11);

        // R8: drain, then empty takes no lock
        for (int i = 0; i < DEPTH + 2; i++) begin
            req(2, 0); step("R8"); idle();
        end
        chk("R8 drained queue", deq_empty[2], 1);
        rel(2, 0); step("R9"); idle();
        req(3, 0); step("R8"); idle();
        tup(1, 2, 3, 4, 5); step("R8"); idle();
        req(0, 0); step("R8"); idle();
        chk("R8 empty took no lock", deq_grant[0], 1);
        step("R6");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule